// File: doc/BRIEF.md
# Layered Decoder Two-Phase Sequencer

This block is the control engine of a layered min-sum decoder for quasi-cyclic LDPC codes that runs without a pipeline. It walks the decoder through its layers and iterations and spends exactly two clock cycles on each layer. In the first cycle it raises the read strobe and holds the shared mode bit low, so the processing units subtract and find the first minimum. In the second cycle it raises the mode bit and the write strobe, so the units add, find the second minimum and write their results back. A layer never begins before the write-back of the layer before it.

Software sets three run values while the decoder is idle: the number of base-matrix rows, how many rows form one layer, and the iteration count. It can also set a small per-layer table with a column position, a cyclic shift amount and an active flag for each edge slot. During a run the sequencer presents the table entry of the current layer to the permutation logic. A start pulse first spends one cycle loading the channel values and then runs every layer of every iteration. A one-cycle done pulse follows the final write-back.

Top module: `ldpc_layer_sequencer`

## Requirements
- R1: After reset, busy, rd_en, wr_en, sel, llr_load and done are 0, layer_idx and iter_idx are 0, and the run values are rows=1, grouping=1 and iterations=1.
- R2: In idle, a start pulse with a nonzero stored row count and iteration count gives llr_load=1 for the next cycle only. The cycle after that is the first read phase, with layer_idx=0 and iter_idx=0.
- R3: Each layer takes exactly two consecutive cycles: rd_en=1 and sel=0 in the first, then wr_en=1 and sel=1 in the second, with the same layer_idx in both. rd_en and wr_en are never high together.
- R4: An iteration holds ceil(rows/group) layers, with layer_idx counting up from 0 by one per layer. A stored group value of 0 acts as 1.
- R5: iter_idx starts at 0 and goes up by one after the last layer of each iteration. A run lasts 2 x layers x iterations phase cycles.
- R6: done is 1 for exactly the one cycle after the final write phase. In that cycle busy is 0, and layer_idx and iter_idx are back to 0.
- R7: A start pulse while busy has no effect on the running sequence.
- R8: Writes to the run values or to the layer table while busy are ignored.
- R9: lay_col, lay_shift and lay_act show the table entry of layer layer_idx. Slot s occupies bits [s*COL_W +: COL_W] of lay_col, bits [s*SHIFT_W +: SHIFT_W] of lay_shift and bit s of lay_act. After reset all entries are 0.
- R10: A start pulse is ignored when the stored row count or the stored iteration count is 0.
- R11: A row count above MAX_ROWS is stored as MAX_ROWS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start a decode run |
| ctl_we | input | 1 | Write the run values |
| ctl_rows | input | ROW_W | Base-matrix rows |
| ctl_group | input | ROW_W | Rows per layer |
| ctl_iters | input | ITER_W | Iteration count |
| cfg_we | input | 1 | Write one layer table slot |
| cfg_layer | input | LAY_W | Layer to write |
| cfg_slot | input | SLOT_W | Edge slot to write |
| cfg_col | input | COL_W | Column position |
| cfg_shift | input | SHIFT_W | Cyclic shift amount |
| cfg_act | input | 1 | Slot active flag |
| busy | output | 1 | Run in progress |
| llr_load | output | 1 | Channel value load cycle |
| rd_en | output | 1 | Read phase strobe |
| wr_en | output | 1 | Write-back phase strobe |
| sel | output | 1 | Shared mode bit (0 first phase, 1 second) |
| layer_idx | output | LAY_W | Current layer |
| iter_idx | output | ITER_W | Current iteration |
| lay_col | output | DCMAX*COL_W | Column positions of the current layer |
| lay_shift | output | DCMAX*SHIFT_W | Shift amounts of the current layer |
| lay_act | output | DCMAX | Active flags of the current layer |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
A wrong phase state shows up at the strobes in the very next cycle, as a doubled read, a missing write or a mode bit that does not match its strobe. A wrong layer or iteration count is seen as a wrong layer_idx at the first layer boundary it touches, or as done arriving early or late by whole layers. A table write that leaks into a busy run changes lay_col or lay_shift within one cycle of the write. The runs sweep every row count up to beyond the clamp, several groupings including zero, and several iteration counts, so each of these faults shows up within one run.

// File: rtl/ldpc_seq_pkg.sv
// Shared types for the layered decoder sequencer.
package ldpc_seq_pkg;
    // Sequencer states: idle, channel load, first phase, second phase.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_RDPH = 2'd2,
        ST_WRPH = 2'd3
    } seq_state_t;
endpackage

// File: rtl/lseq_ctl_regs.sv
// Run value registers: row count, rows per layer, iteration count.
// Assumes the caller gates wr_ok with idle. Rows are clamped to MAX_ROWS
// and a grouping of zero is stored as one.
module lseq_ctl_regs #(
    parameter int MAX_ROWS = 16,
    parameter int ROW_W    = 5,
    parameter int ITER_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic [ROW_W-1:0]  rows_i,
    input  logic [ROW_W-1:0]  group_i,
    input  logic [ITER_W-1:0] iters_i,
    output logic [ROW_W-1:0]  rows_q,
    output logic [ROW_W-1:0]  group_q,
    output logic [ITER_W-1:0] iters_q
);
    localparam logic [ROW_W-1:0] ROWS_CAP = ROW_W'(MAX_ROWS);

    logic [ROW_W-1:0] rows_clamped;
    logic [ROW_W-1:0] group_clamped;

    // Clamp the incoming values before they are stored.
    always_comb begin
        rows_clamped  = (rows_i > ROWS_CAP) ? ROWS_CAP : rows_i;
        group_clamped = (group_i == '0) ? ROW_W'(1) : group_i;
    end

    // Hold the run values; reset selects one row, one per layer, one pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rows_q  <= ROW_W'(1);
            group_q <= ROW_W'(1);
            iters_q <= ITER_W'(1);
        end else if (wr_ok) begin
            rows_q  <= rows_clamped;
            group_q <= group_clamped;
            iters_q <= iters_i;
        end
    end
endmodule

// File: rtl/lseq_cfg_file.sv
// Per-layer edge table: column position, shift amount and active flag for
// each slot. One slot is written per cycle and the whole entry of one layer
// is read out combinationally. Assumes the caller gates we_ok with idle.
module lseq_cfg_file #(
    parameter int LAYERS  = 16,
    parameter int DCMAX   = 8,
    parameter int COL_W   = 5,
    parameter int SHIFT_W = 7,
    parameter int LAY_W   = 4,
    parameter int SLOT_W  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we_ok,
    input  logic [LAY_W-1:0]         wr_layer,
    input  logic [SLOT_W-1:0]        wr_slot,
    input  logic [COL_W-1:0]         wr_col,
    input  logic [SHIFT_W-1:0]       wr_shift,
    input  logic                     wr_act,
    input  logic [LAY_W-1:0]         rd_layer,
    output logic [DCMAX*COL_W-1:0]   rd_col,
    output logic [DCMAX*SHIFT_W-1:0] rd_shift,
    output logic [DCMAX-1:0]         rd_act
);
    logic [COL_W-1:0]   col_q   [LAYERS][DCMAX];
    logic [SHIFT_W-1:0] shift_q [LAYERS][DCMAX];
    logic               act_q   [LAYERS][DCMAX];

    for (genvar l = 0; l < LAYERS; l++) begin : g_layer
        for (genvar s = 0; s < DCMAX; s++) begin : g_slot
            logic hit;
            assign hit = we_ok && (wr_layer == LAY_W'(l)) && (wr_slot == SLOT_W'(s));

            // Store one slot of one layer; reset clears it.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    col_q[l][s]   <= '0;
                    shift_q[l][s] <= '0;
                    act_q[l][s]   <= 1'b0;
                end else if (hit) begin
                    col_q[l][s]   <= wr_col;
                    shift_q[l][s] <= wr_shift;
                    act_q[l][s]   <= wr_act;
                end
            end
        end
    end

    for (genvar s = 0; s < DCMAX; s++) begin : g_rd
        // Present slot s of the selected layer.
        always_comb begin
            rd_col[s*COL_W +: COL_W]       = col_q[rd_layer][s];
            rd_shift[s*SHIFT_W +: SHIFT_W] = shift_q[rd_layer][s];
            rd_act[s]                      = act_q[rd_layer][s];
        end
    end
endmodule

// File: rtl/lseq_walk.sv
// Layer and iteration walker. A layer is a group of consecutive base rows;
// the first row of the current layer is tracked so that the last layer is
// found without dividing. Assumes group >= 1 and iters >= 1 while stepping.
module lseq_walk #(
    parameter int ROW_W  = 5,
    parameter int LAY_W  = 4,
    parameter int ITER_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic [ROW_W-1:0]  rows,
    input  logic [ROW_W-1:0]  group,
    input  logic [ITER_W-1:0] iters,
    output logic [LAY_W-1:0]  layer_idx,
    output logic [ITER_W-1:0] iter_idx,
    output logic              last_layer,
    output logic              last_iter
);
    logic [ROW_W-1:0] row_base;
    logic [ROW_W:0]   next_base;

    // Flag the final layer of the pass and the final pass.
    always_comb begin
        next_base  = {1'b0, row_base} + {1'b0, group};
        last_layer = (next_base >= {1'b0, rows});
        last_iter  = (iter_idx == (iters - ITER_W'(1)));
    end

    // Advance row base, layer and iteration at the end of each layer.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            row_base  <= '0;
            layer_idx <= '0;
            iter_idx  <= '0;
        end else if (step) begin
            if (last_layer) begin
                row_base  <= '0;
                layer_idx <= '0;
                iter_idx  <= iter_idx + ITER_W'(1);
            end else begin
                row_base  <= next_base[ROW_W-1:0];
                layer_idx <= layer_idx + LAY_W'(1);
            end
        end
    end
endmodule

// File: rtl/ldpc_layer_sequencer.sv
// Two-phase control engine of a layered min-sum decoder without a pipeline.
// Each layer uses one read/first-minimum cycle (sel=0) and one
// write/second-minimum cycle (sel=1). Run values and the layer table may
// only change while idle.
module ldpc_layer_sequencer #(
    parameter int MAX_ROWS = 16,
    parameter int DCMAX    = 8,
    parameter int COL_W    = 5,
    parameter int SHIFT_W  = 7,
    parameter int ITER_W   = 6,
    parameter int ROW_W    = $clog2(MAX_ROWS + 1),
    parameter int LAY_W    = $clog2(MAX_ROWS),
    parameter int SLOT_W   = $clog2(DCMAX)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     ctl_we,
    input  logic [ROW_W-1:0]         ctl_rows,
    input  logic [ROW_W-1:0]         ctl_group,
    input  logic [ITER_W-1:0]        ctl_iters,
    input  logic                     cfg_we,
    input  logic [LAY_W-1:0]         cfg_layer,
    input  logic [SLOT_W-1:0]        cfg_slot,
    input  logic [COL_W-1:0]         cfg_col,
    input  logic [SHIFT_W-1:0]       cfg_shift,
    input  logic                     cfg_act,
    output logic                     busy,
    output logic                     llr_load,
    output logic                     rd_en,
    output logic                     wr_en,
    output logic                     sel,
    output logic [LAY_W-1:0]         layer_idx,
    output logic [ITER_W-1:0]        iter_idx,
    output logic [DCMAX*COL_W-1:0]   lay_col,
    output logic [DCMAX*SHIFT_W-1:0] lay_shift,
    output logic [DCMAX-1:0]         lay_act,
    output logic                     done
);
    import ldpc_seq_pkg::*;

    seq_state_t        state_q, state_d;
    logic [ROW_W-1:0]  rows_q, group_q;
    logic [ITER_W-1:0] iters_q;
    logic              idle, start_ok, final_wr, walk_clear, walk_step;
    logic              last_layer, last_iter;

    assign idle = (state_q == ST_IDLE);

    lseq_ctl_regs #(.MAX_ROWS(MAX_ROWS), .ROW_W(ROW_W), .ITER_W(ITER_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .wr_ok(ctl_we && idle),
        .rows_i(ctl_rows), .group_i(ctl_group), .iters_i(ctl_iters),
        .rows_q(rows_q), .group_q(group_q), .iters_q(iters_q)
    );

    lseq_cfg_file #(
        .LAYERS(MAX_ROWS), .DCMAX(DCMAX), .COL_W(COL_W), .SHIFT_W(SHIFT_W),
        .LAY_W(LAY_W), .SLOT_W(SLOT_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .we_ok(cfg_we && idle),
        .wr_layer(cfg_layer), .wr_slot(cfg_slot), .wr_col(cfg_col),
        .wr_shift(cfg_shift), .wr_act(cfg_act), .rd_layer(layer_idx),
        .rd_col(lay_col), .rd_shift(lay_shift), .rd_act(lay_act)
    );

    lseq_walk #(.ROW_W(ROW_W), .LAY_W(LAY_W), .ITER_W(ITER_W)) u_walk (
        .clk(clk), .rst_n(rst_n), .clear(walk_clear), .step(walk_step),
        .rows(rows_q), .group(group_q), .iters(iters_q),
        .layer_idx(layer_idx), .iter_idx(iter_idx),
        .last_layer(last_layer), .last_iter(last_iter)
    );

    // Decide acceptance of a start and detect the final write phase.
    always_comb begin
        start_ok   = start && idle && (rows_q != '0) && (iters_q != '0);
        final_wr   = (state_q == ST_WRPH) && last_layer && last_iter;
        walk_clear = start_ok || final_wr;
        walk_step  = (state_q == ST_WRPH) && !final_wr;
    end

    // Next-state logic of the two-phase schedule.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_ok) state_d = ST_LOAD;
            ST_LOAD: state_d = ST_RDPH;
            ST_RDPH: state_d = ST_WRPH;
            ST_WRPH: state_d = final_wr ? ST_IDLE : ST_RDPH;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and the registered end-of-run pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done    <= 1'b0;
        end else begin
            state_q <= state_d;
            done    <= final_wr;
        end
    end

    // Decode the strobes from the state.
    always_comb begin
        busy     = !idle;
        llr_load = (state_q == ST_LOAD);
        rd_en    = (state_q == ST_RDPH);
        wr_en    = (state_q == ST_WRPH);
        sel      = (state_q == ST_WRPH);
    end
endmodule

// File: rtl/lseq_sva.sv
// Protocol checker for the sequencer, bound to the top module.
module lseq_sva #(
    parameter int DCMAX   = 8,
    parameter int COL_W   = 5,
    parameter int SHIFT_W = 7,
    parameter int ITER_W  = 6,
    parameter int LAY_W   = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     busy,
    input logic                     llr_load,
    input logic                     rd_en,
    input logic                     wr_en,
    input logic                     sel,
    input logic [LAY_W-1:0]         layer_idx,
    input logic [ITER_W-1:0]        iter_idx,
    input logic [DCMAX*COL_W-1:0]   lay_col,
    input logic [DCMAX*SHIFT_W-1:0] lay_shift,
    input logic                     done
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(rd_en && wr_en)); // R3
    AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n) rd_en |=> (wr_en && sel)); // R3
    AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> $past(rd_en)); // R3
    AST_RD_MODE_LOW: assert property (@(posedge clk) disable iff (!rst_n) rd_en |-> !sel); // R3
    AST_LAYER_HELD: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> $stable(layer_idx)); // R3
    AST_LOAD_THEN_RD: assert property (@(posedge clk) disable iff (!rst_n)
        llr_load |=> (rd_en && layer_idx == '0 && iter_idx == '0)); // R2
    AST_DONE_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n) done |-> ($past(wr_en) && !busy)); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R6
    AST_TABLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && $stable(layer_idx)) |-> ($stable(lay_col) && $stable(lay_shift))); // R8
endmodule

bind ldpc_layer_sequencer lseq_sva #(
    .DCMAX(DCMAX), .COL_W(COL_W), .SHIFT_W(SHIFT_W), .ITER_W(ITER_W), .LAY_W(LAY_W)
) u_sva (
    .clk(clk), .rst_n(rst_n), .busy(busy), .llr_load(llr_load), .rd_en(rd_en),
    .wr_en(wr_en), .sel(sel), .layer_idx(layer_idx), .iter_idx(iter_idx),
    .lay_col(lay_col), .lay_shift(lay_shift), .done(done)
);

// File: tb/ldpc_layer_sequencer_tb.sv
// Sweep bench: every row count 0..20, groupings 0..5, iteration counts 0..3.
module ldpc_layer_sequencer_tb;
    localparam int MAX_ROWS = 16;
    localparam int DCMAX    = 8;
    localparam int COL_W    = 5;
    localparam int SHIFT_W  = 7;
    localparam int ITER_W   = 6;
    localparam int ROW_W    = $clog2(MAX_ROWS + 1);
    localparam int LAY_W    = $clog2(MAX_ROWS);
    localparam int SLOT_W   = $clog2(DCMAX);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, ctl_we = 1'b0, cfg_we = 1'b0, cfg_act = 1'b0;
    logic [ROW_W-1:0] ctl_rows = '0, ctl_group = '0;
    logic [ITER_W-1:0] ctl_iters = '0;
    logic [LAY_W-1:0] cfg_layer = '0;
    logic [SLOT_W-1:0] cfg_slot = '0;
    logic [COL_W-1:0] cfg_col = '0;
    logic [SHIFT_W-1:0] cfg_shift = '0;
    logic busy, llr_load, rd_en, wr_en, sel, done;
    logic [LAY_W-1:0] layer_idx;
    logic [ITER_W-1:0] iter_idx;
    logic [DCMAX*COL_W-1:0] lay_col;
    logic [DCMAX*SHIFT_W-1:0] lay_shift;
    logic [DCMAX-1:0] lay_act;

    int vectors = 0;
    int misses = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ldpc_layer_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ctl_we(ctl_we),
        .ctl_rows(ctl_rows), .ctl_group(ctl_group), .ctl_iters(ctl_iters),
        .cfg_we(cfg_we), .cfg_layer(cfg_layer), .cfg_slot(cfg_slot),
        .cfg_col(cfg_col), .cfg_shift(cfg_shift), .cfg_act(cfg_act),
        .busy(busy), .llr_load(llr_load), .rd_en(rd_en), .wr_en(wr_en),
        .sel(sel), .layer_idx(layer_idx), .iter_idx(iter_idx),
        .lay_col(lay_col), .lay_shift(lay_shift), .lay_act(lay_act), .done(done)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic logic [DCMAX*COL_W-1:0] exp_col(input int l);
        logic [DCMAX*COL_W-1:0] v = '0;
        for (int s = 0; s < DCMAX; s++) v[s*COL_W +: COL_W] = COL_W'((l * 3 + s * 5 + 1) % 32);
        return v;
    endfunction

    function automatic logic [DCMAX*SHIFT_W-1:0] exp_shift(input int l);
        logic [DCMAX*SHIFT_W-1:0] v = '0;
        for (int s = 0; s < DCMAX; s++) v[s*SHIFT_W +: SHIFT_W] = SHIFT_W'((l * 11 + s * 7 + 2) % 128);
        return v;
    endfunction

    function automatic logic [DCMAX-1:0] exp_act(input int l);
        logic [DCMAX-1:0] v = '0;
        for (int s = 0; s < DCMAX; s++) v[s] = ((l + s) % 3) != 0;
        return v;
    endfunction

    task automatic write_ctl(input int rows, input int grp, input int iters);
        ctl_we = 1'b1; ctl_rows = ROW_W'(rows); ctl_group = ROW_W'(grp); ctl_iters = ITER_W'(iters);
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    // Check the strobes of one phase cycle at the current negedge.
    task automatic check_phase(input bit second, input int l, input int it);
        check(second ? "R3 wr_en" : "R3 rd_en", {63'd0, second ? wr_en : rd_en}, 64'd1);
        check("R3 other strobe", {63'd0, second ? rd_en : wr_en}, 64'd0);
        check("R3 sel", {63'd0, sel}, {63'd0, second});
        check("R4 layer_idx", 64'(layer_idx), 64'(l));
        check("R5 iter_idx", 64'(iter_idx), 64'(it));
        check("R6 no early done", {63'd0, done}, 64'd0);
        check("R9 lay_col", 64'(lay_col), 64'(exp_col(l)));
        check("R9 lay_shift", 64'(lay_shift), 64'(exp_shift(l)));
        check("R9 lay_act", 64'(lay_act), 64'(exp_act(l)));
    endtask

    // One run; stored values rows/grp/iters; inject pokes start and writes mid-run.
    task automatic run_one(input int rows, input int grp, input int iters, input bit inject);
        int rows_e, grp_e, nlay;
        rows_e = (rows > MAX_ROWS) ? MAX_ROWS : rows;
        grp_e  = (grp == 0) ? 1 : grp;
        nlay   = (rows_e + grp_e - 1) / grp_e;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (rows_e == 0 || iters == 0) begin
            check("R10 no load", {63'd0, llr_load}, 64'd0);
            check("R10 stays idle", {63'd0, busy}, 64'd0);
            @(negedge clk);
            check("R10 no read", {63'd0, rd_en}, 64'd0);
            return;
        end
        check("R2 llr_load", {63'd0, llr_load}, 64'd1);
        check("R2 busy", {63'd0, busy}, 64'd1);
        for (int it = 0; it < iters; it++) begin
            for (int l = 0; l < nlay; l++) begin
                @(negedge clk);
                check_phase(1'b0, l, it);
                if (inject && it == 0 && l == 1) begin
                    start = 1'b1; // R7: start while busy
                    ctl_we = 1'b1; ctl_rows = ROW_W'(1); ctl_group = ROW_W'(1); ctl_iters = ITER_W'(1);
                    cfg_we = 1'b1; cfg_layer = LAY_W'(1); cfg_slot = '0;
                    cfg_col = ~exp_col(1)[COL_W-1:0]; cfg_shift = ~exp_shift(1)[SHIFT_W-1:0];
                    cfg_act = ~exp_act(1)[0];
                end
                @(negedge clk);
                start = 1'b0; ctl_we = 1'b0; cfg_we = 1'b0;
                check_phase(1'b1, l, it);
            end
        end
        @(negedge clk);
        check("R6 done", {63'd0, done}, 64'd1);
        check("R6 idle at done", {63'd0, busy}, 64'd0);
        check("R6 layer cleared", 64'(layer_idx), 64'd0);
        check("R6 iter cleared", 64'(iter_idx), 64'd0);
        @(negedge clk);
        check("R6 done one cycle", {63'd0, done}, 64'd0);
        check("R5 no extra phase", {63'd0, rd_en | wr_en}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy", {63'd0, busy}, 64'd0);
        check("R1 strobes", {60'd0, llr_load, rd_en, wr_en, sel}, 64'd0);
        check("R1 done", {63'd0, done}, 64'd0);
        check("R1 counters", 64'({layer_idx, iter_idx}), 64'd0);
        check("R9 reset table", 64'({lay_act, lay_col}), 64'd0);
        // R1: reset run values give one layer and one pass.
        begin
            logic [DCMAX*COL_W-1:0] c0;
            c0 = '0;
            start = 1'b1; @(negedge clk); start = 1'b0;
            check("R1 default load", {63'd0, llr_load}, 64'd1);
            @(negedge clk); check("R1 default rd", {63'd0, rd_en}, 64'd1);
            @(negedge clk); check("R1 default wr", {63'd0, wr_en}, 64'd1);
            check("R9 reset col", 64'(lay_col), 64'(c0));
            @(negedge clk); check("R1 default done", {63'd0, done}, 64'd1);
            @(negedge clk);
        end
        // Fill the layer table while idle.
        for (int l = 0; l < MAX_ROWS; l++) begin
            for (int s = 0; s < DCMAX; s++) begin
                cfg_we = 1'b1; cfg_layer = LAY_W'(l); cfg_slot = SLOT_W'(s);
                cfg_col = exp_col(l)[s*COL_W +: COL_W];
                cfg_shift = exp_shift(l)[s*SHIFT_W +: SHIFT_W];
                cfg_act = exp_act(l)[s];
                @(negedge clk);
            end
        end
        cfg_we = 1'b0;
        @(negedge clk);
        check("R9 idle view layer0", 64'(lay_col), 64'(exp_col(0)));
        // Main sweep (R4, R5, R10, R11).
        for (int rows = 0; rows <= 20; rows++) begin
            for (int grp = 0; grp <= 5; grp++) begin
                for (int iters = 0; iters <= 3; iters++) begin
                    write_ctl(rows, grp, iters);
                    run_one(rows, grp, iters, 1'b0);
                end
            end
        end
        // R7, R8: start and writes during a run are ignored; then rerun unchanged.
        write_ctl(12, 1, 2);
        run_one(12, 1, 2, 1'b1);
        run_one(12, 1, 2, 1'b0);
        write_ctl(12, 4, 3);
        run_one(12, 4, 3, 1'b1);
        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            misses++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule